// File: doc/BRIEF.md
# HDLC Transmit FIFO Host Controller

This block sits between a host processor and an HDLC transmit serializer. The host loads frame bytes into a local transmit FIFO, one block at a time, and then gives a transmit command. If that command also carries end-of-message, the frame is closed. A second block-size setting selects whether one chunk is 16 or 32 bytes. The block streams the stored bytes to the serializer over a ready/valid byte handshake and flags the final byte of a closed frame. The serializer does the flags, bit stuffing and CRC.

The host learns when it may load more data from a pool-ready interrupt. The timing of that interrupt depends on how the last command was given. If the FIFO drains while a frame is still open, the block asks the serializer to abort the frame with seven ones and raises an underrun interrupt. A collision reported by the line after the first block of a frame raises a repeat interrupt, and the host must then resend the frame. A collision inside the first block is absorbed: the block restarts the frame from its retained copy. After an underrun or a repeat event, host writes are refused until the host reads that status. A mask register hides interrupt sources, and a hidden source can never be cleared by a read.

Top module: `hdlc_txq_ctrl`

## Requirements
- R1: After reset the status holds pool-ready (status bit 0) set and underrun (bit 1) and repeat (bit 2) clear. The mask reads 0xFC, `irq` is high, `line_valid` is low and `wr_lock` is low.
- R2: `stat_q` equals status AND NOT mask, where a mask bit of 1 hides that source. A read strobe clears exactly the visible bits. `irq` is high when any visible bit is set.
- R3: After each transmit command, at most one block of host writes is accepted: 16 bytes when `blk_sel` is 0 and 32 when it is 1. Further writes are dropped.
- R4: Bytes leave on the line in the order they were written, and `line_last` is high only with the final byte of a frame closed by end-of-message.
- R5: After a transmit command without end-of-message, pool-ready is set once the free FIFO space is at least one block. Space taken by a frame's first block is not freed until that block has been sent.
- R6: After a transmit command with end-of-message, pool-ready is set only when the final byte of the frame has been accepted by the line.
- R7: When an open frame finds the FIFO empty, `line_abort` pulses for one cycle, the underrun bit (bit 1) is set and the FIFO is emptied.
- R8: A collision after the first block of a frame has been sent sets the repeat bit (bit 2) and drops the frame without an abort request.
- R9: A collision while the first block is still being sent restarts the frame from its first byte and sets no status bit.
- R10: While underrun or repeat status is pending, `wr_lock` is high and host writes are ignored. A read that clears those bits releases the lock.
- R11: A masked underrun or repeat bit is not cleared by a read, so the lock stays until the source is unmasked and read.
- R12: A transmitter-reset command empties the FIFO, ends any frame and sets pool-ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_sel | input | 1 | Block size: 0 = 16 bytes, 1 = 32 bytes |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DW | Host write byte |
| wr_lock | output | 1 | FIFO refuses writes (underrun or repeat pending) |
| cmd_xmit | input | 1 | Transmit-data command pulse |
| cmd_eom | input | 1 | End-of-message, qualified by `cmd_xmit` |
| cmd_txreset | input | 1 | Transmitter reset command pulse |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write value (1 = hidden) |
| mask_q | output | 8 | Current mask |
| stat_rd | input | 1 | Status read strobe (clear on read) |
| stat_q | output | 8 | Visible status: bit0 pool-ready, bit1 underrun, bit2 repeat |
| irq | output | 1 | Interrupt request |
| line_valid | output | 1 | Byte offered to serializer |
| line_ready | input | 1 | Serializer accepts byte |
| line_data | output | DW | Byte to serializer |
| line_last | output | 1 | Offered byte ends the frame |
| line_abort | output | 1 | One-cycle request to abort with seven ones |
| coll_in | input | 1 | Collision pulse from the line |

## Verification
Every cycle, the assertions check that the abort request lasts a single cycle and always leaves the FIFO locked, and that an offered byte holds steady until it is taken. They also check that a pending lock survives every cycle without a read, and every read while both lock sources are masked, and that the end-of-frame flag comes only with an offered byte. Byte order, the timing of pool-ready for open and closed frames, the block write limit, the two collision outcomes and recovery after a read show only in the bench scenarios, which compare the captured line bytes and status values against expected values.

// File: rtl/hdlc_txq_pkg.sv
// Shared constants for the HDLC transmit FIFO host controller.
// Assumes an 8-bit status/mask register; bit positions are fixed.
package hdlc_txq_pkg;
    localparam int ST_W = 8;
    localparam int B_XPR = 0;   // pool ready
    localparam int B_XDU = 1;   // underrun
    localparam int B_XMR = 2;   // repeat request
    localparam logic [ST_W-1:0] ST_RST   = 8'h01;
    localparam logic [ST_W-1:0] MASK_RST = 8'hFC;
endpackage

// File: rtl/txq_store.sv
// Byte storage of the transmit FIFO: one write port, one asynchronous read.
// Assumes DEPTH is a power of two; contents are not reset.
module txq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store an accepted host byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the byte at the read pointer.
    assign rdata = mem[raddr];
endmodule

// File: rtl/txq_irq_regs.sv
// Sticky interrupt status, mask register, clear-on-read and FIFO lock.
// Assumes events arrive as single-cycle set pulses; a set wins over a clear.
module txq_irq_regs
    import hdlc_txq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_xpr,
    input  logic            ev_xdu,
    input  logic            ev_xmr,
    input  logic            mask_we,
    input  logic [ST_W-1:0] mask_wdata,
    input  logic            rd_stb,
    output logic [ST_W-1:0] rd_data,
    output logic [ST_W-1:0] mask_q,
    output logic            irq,
    output logic            lock
);
    logic [ST_W-1:0] st;
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] clr_vec;

    // Gather event pulses and the read-clear pattern.
    always_comb begin
        set_vec        = '0;
        set_vec[B_XPR] = ev_xpr;
        set_vec[B_XDU] = ev_xdu;
        set_vec[B_XMR] = ev_xmr;
        clr_vec        = rd_stb ? ~mask_q : '0;
    end

    // Sticky status with clear-on-read of visible bits.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RST;
        else        st <= (st & ~clr_vec) | set_vec;
    end

    // Host-written mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= MASK_RST;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign rd_data = st & ~mask_q;
    assign irq     = |rd_data;
    assign lock    = st[B_XDU] | st[B_XMR];
endmodule

// File: rtl/txq_seq.sv
// Transmit sequencer: pointers, block write limit, frame state, underrun,
// collision handling and pool-ready event generation.
// Assumes DEPTH is a power of two and DEPTH >= BLK_L. A collision or
// transmitter reset in a cycle overrides a line handshake in that cycle.
module txq_seq #(
    parameter int DEPTH = 64,
    parameter int BLK_S = 16,
    parameter int BLK_L = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int CW   = $clog2(BLK_L) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_sel,
    input  logic          wr_en,
    input  logic          lock,
    input  logic          cmd_xmit,
    input  logic          cmd_eom,
    input  logic          cmd_txres,
    input  logic          line_ready,
    input  logic          coll_in,
    output logic          wr_acc,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          line_valid,
    output logic          line_last,
    output logic          line_abort,
    output logic          ev_xpr,
    output logic          ev_xdu,
    output logic          ev_xmr
);
    logic [PW-1:0] wr_ptr, rd_ptr, base_ptr;
    logic [CW-1:0] blk_cnt, sent;
    logic          active, eom_q, arm;
    logic [CW-1:0] blk;
    logic [PW-1:0] used, rd_nxt;
    logic [PW:0]   space;
    logic          full, avail, fire, coll_hit, first_blk;
    logic          retry, rep, udr, flush, xpr_part, done;

    // Derived occupancy, handshake and event terms.
    always_comb begin
        blk       = blk_sel ? CW'(BLK_L) : CW'(BLK_S);
        used      = wr_ptr - base_ptr;
        space     = (PW+1)'(DEPTH) - {1'b0, used};
        full      = ({1'b0, used} >= (PW+1)'(DEPTH));
        rd_nxt    = rd_ptr + PW'(1);
        avail     = (rd_ptr != wr_ptr);
        first_blk = (sent < blk);
        coll_hit  = active && coll_in && !cmd_txres;
        retry     = coll_hit && first_blk;
        rep       = coll_hit && !first_blk;
        udr       = active && !eom_q && !avail && !coll_hit && !cmd_txres;
        flush     = rep || udr;
        fire      = line_valid && line_ready && !coll_hit && !cmd_txres;
        done      = fire && line_last;
        xpr_part  = arm && active && !eom_q && !cmd_txres
                    && (space >= {{(PW+1-CW){1'b0}}, blk});
        wr_acc    = wr_en && !lock && !full && (blk_cnt < blk) && !cmd_txres;
    end

    assign waddr      = wr_ptr[AW-1:0];
    assign raddr      = rd_ptr[AW-1:0];
    assign line_valid = active && avail;
    assign line_last  = line_valid && eom_q && (rd_nxt == wr_ptr);
    assign line_abort = udr;
    assign ev_xpr     = cmd_txres || xpr_part || done;
    assign ev_xdu     = udr;
    assign ev_xmr     = rep;

    // Pointer and frame state update; later statements take priority.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_txres) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            base_ptr <= '0;
            blk_cnt  <= '0;
            sent     <= '0;
            active   <= 1'b0;
            eom_q    <= 1'b0;
            arm      <= 1'b0;
        end else begin
            if (wr_acc) begin
                wr_ptr  <= wr_ptr + PW'(1);
                blk_cnt <= blk_cnt + CW'(1);
            end
            if (cmd_xmit) begin
                active  <= 1'b1;
                blk_cnt <= '0;
                eom_q   <= cmd_eom;
                arm     <= !cmd_eom;
            end
            if (xpr_part) arm <= 1'b0;
            if (flush) begin
                wr_ptr   <= '0;
                rd_ptr   <= '0;
                base_ptr <= '0;
                blk_cnt  <= '0;
                sent     <= '0;
                active   <= 1'b0;
                eom_q    <= 1'b0;
                arm      <= 1'b0;
            end else if (retry) begin
                rd_ptr <= base_ptr;
                sent   <= '0;
            end else if (fire) begin
                rd_ptr <= rd_nxt;
                if (first_blk) sent <= sent + CW'(1);
                if (!first_blk || (sent + CW'(1) >= blk)) base_ptr <= rd_nxt;
                if (done) begin
                    base_ptr <= rd_nxt;
                    sent     <= '0;
                    active   <= 1'b0;
                    eom_q    <= 1'b0;
                    arm      <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_txq_ctrl.sv
// HDLC transmit FIFO host controller top: ties storage, sequencer and
// interrupt registers together. Assumes a single clock domain and that
// the serializer takes one byte per handshake.
module hdlc_txq_ctrl
    import hdlc_txq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int BLK_S = 16,
    parameter int BLK_L = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blk_sel,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    output logic            wr_lock,
    input  logic            cmd_xmit,
    input  logic            cmd_eom,
    input  logic            cmd_txreset,
    input  logic            mask_we,
    input  logic [ST_W-1:0] mask_wdata,
    output logic [ST_W-1:0] mask_q,
    input  logic            stat_rd,
    output logic [ST_W-1:0] stat_q,
    output logic            irq,
    output logic            line_valid,
    input  logic            line_ready,
    output logic [DW-1:0]   line_data,
    output logic            line_last,
    output logic            line_abort,
    input  logic            coll_in
);
    logic          wr_acc, ev_xpr, ev_xdu, ev_xmr;
    logic [AW-1:0] waddr, raddr;

    txq_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
        .clk(clk), .we(wr_acc), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(line_data)
    );

    txq_seq #(.DEPTH(DEPTH), .BLK_S(BLK_S), .BLK_L(BLK_L)) i_seq (
        .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .wr_en(wr_en),
        .lock(wr_lock), .cmd_xmit(cmd_xmit), .cmd_eom(cmd_eom),
        .cmd_txres(cmd_txreset), .line_ready(line_ready), .coll_in(coll_in),
        .wr_acc(wr_acc), .waddr(waddr), .raddr(raddr),
        .line_valid(line_valid), .line_last(line_last),
        .line_abort(line_abort), .ev_xpr(ev_xpr), .ev_xdu(ev_xdu),
        .ev_xmr(ev_xmr)
    );

    txq_irq_regs i_irq (
        .clk(clk), .rst_n(rst_n), .ev_xpr(ev_xpr), .ev_xdu(ev_xdu),
        .ev_xmr(ev_xmr), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .rd_stb(stat_rd), .rd_data(stat_q), .mask_q(mask_q), .irq(irq),
        .lock(wr_lock)
    );
endmodule

// File: rtl/hdlc_txq_ctrl_chk.sv
// Property checker for hdlc_txq_ctrl, attached through bind.
// Assumes the bound instance uses the default status layout.
module hdlc_txq_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_lock,
    input logic          stat_rd,
    input logic [7:0]    mask_q,
    input logic          cmd_txreset,
    input logic          coll_in,
    input logic          line_valid,
    input logic          line_ready,
    input logic [DW-1:0] line_data,
    input logic          line_last,
    input logic          line_abort
);
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_abort |=> !line_abort); // R7
    AST_ABORT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        line_abort |=> wr_lock); // R10
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        line_last |-> line_valid); // R4
    AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_ready && !coll_in && !cmd_txreset)
        |=> (line_valid && $stable(line_data))); // R4
    AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && !stat_rd) |=> wr_lock); // R10
    AST_MASKED_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && stat_rd && mask_q[1] && mask_q[2]) |=> wr_lock); // R11
endmodule

bind hdlc_txq_ctrl hdlc_txq_ctrl_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .stat_rd(stat_rd),
    .mask_q(mask_q), .cmd_txreset(cmd_txreset), .coll_in(coll_in),
    .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data),
    .line_last(line_last), .line_abort(line_abort)
);

// File: tb/test_hdlc_txq_ctrl.sv
// Self-checking bench for hdlc_txq_ctrl: a frame table walked by one loop,
// then directed scenarios for reset, limits, underrun, collisions and locks.
module test_hdlc_txq_ctrl;
    localparam int CLK_P = 10;
    // Frame table: [15] blk_sel, [14:8] length, [7:0] first byte value.
    localparam logic [15:0] FRAMES [4] = '{
        {1'b0, 7'd16, 8'h10}, {1'b1, 7'd32, 8'h60},
        {1'b0, 7'd5,  8'hA0}, {1'b1, 7'd20, 8'hC0}
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       blk_sel = 1'b0, wr_en = 1'b0, cmd_xmit = 1'b0, cmd_eom = 1'b0;
    logic       cmd_txreset = 1'b0, mask_we = 1'b0, stat_rd = 1'b0;
    logic       line_ready = 1'b0, coll_in = 1'b0;
    logic [7:0] wr_data = '0, mask_wdata = '0;
    logic       wr_lock, irq, line_valid, line_last, line_abort;
    logic [7:0] mask_q, stat_q, line_data;

    int         checks = 0, errors = 0, rx_cnt = 0, abort_cnt = 0, last_cnt = 0;
    logic [7:0] rx [256];
    logic       rx_lf [256];
    bit         finished = 0;

    hdlc_txq_ctrl i_hdlc_txq_ctrl (
        .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .wr_en(wr_en),
        .wr_data(wr_data), .wr_lock(wr_lock), .cmd_xmit(cmd_xmit),
        .cmd_eom(cmd_eom), .cmd_txreset(cmd_txreset), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask_q(mask_q), .stat_rd(stat_rd),
        .stat_q(stat_q), .irq(irq), .line_valid(line_valid),
        .line_ready(line_ready), .line_data(line_data), .line_last(line_last),
        .line_abort(line_abort), .coll_in(coll_in)
    );

    always #(CLK_P/2) clk = ~clk;

    // Line monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_valid && line_ready && rx_cnt < 256) begin
                rx[rx_cnt]    = line_data;
                rx_lf[rx_cnt] = line_last;
                rx_cnt++;
                if (line_last) last_cnt++;
            end
            if (line_abort) abort_cnt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; tick(1); wr_en = 1'b0;
    endtask

    task automatic cmd(input logic e);
        cmd_xmit = 1'b1; cmd_eom = e; tick(1); cmd_xmit = 1'b0; cmd_eom = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        stat_rd = 1'b1; #1 v = stat_q; tick(1); stat_rd = 1'b0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_we = 1'b1; mask_wdata = m; tick(1); mask_we = 1'b0;
    endtask

    task automatic clear_rx();
        rx_cnt = 0; last_cnt = 0;
    endtask

    // Send a short closed frame and confirm only its bytes appear.
    task automatic short_frame(input logic [7:0] b0, input string req);
        clear_rx();
        line_ready = 1'b1;
        put(b0); put(b0 + 8'd1);
        cmd(1'b1);
        tick(6);
        check(rx_cnt == 2 && rx[0] == b0 && rx[1] == b0 + 8'd1, req,
              {rx_cnt[7:0], rx[0]}, {8'd2, b0});
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog.
    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int         bad;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state.
        check(stat_q == 8'h01, "R1 status", stat_q, 8'h01);
        check(mask_q == 8'hFC, "R1 mask", mask_q, 8'hFC);
        check(irq && !line_valid && !wr_lock, "R1 irq/valid/lock",
              {irq, line_valid, wr_lock}, 3'b100);
        // R2: read returns visible bits and clears them.
        rd_stat(v);
        check(v == 8'h01, "R2 read value", v, 8'h01);
        tick(1);
        check(!irq && stat_q == 8'h00, "R2 cleared", {irq, stat_q}, 0);

        // Table of closed frames: R4 order/last, R6 pool-ready timing.
        foreach (FRAMES[k]) begin
            logic [15:0] f;
            int          len;
            f = FRAMES[k];
            len = int'(f[14:8]);
            blk_sel = f[15];
            rd_stat(v);
            clear_rx();
            line_ready = 1'b0;
            for (int i = 0; i < len; i++) put(f[7:0] + 8'(i));
            cmd(1'b1);
            tick(3);
            check(!irq, "R6 no early pool-ready", irq, 0);
            line_ready = 1'b1;
            tick(len + 3);
            check(rx_cnt == len, "R4 byte count", rx_cnt, len);
            bad = 0;
            for (int i = 0; i < len; i++) if (rx[i] != f[7:0] + 8'(i)) bad++;
            check(bad == 0, "R4 byte order", bad, 0);
            check(last_cnt == 1 && rx_lf[len-1], "R4 last flag", last_cnt, 1);
            check(stat_q[0], "R6 pool-ready after frame", stat_q, 1);
        end

        // R3: block limit of 16 bytes.
        blk_sel = 1'b0;
        rd_stat(v);
        clear_rx();
        line_ready = 1'b0;
        for (int i = 0; i < 20; i++) put(8'h40 + 8'(i));
        line_ready = 1'b1;
        cmd(1'b1);
        tick(22);
        check(rx_cnt == 16 && rx[15] == 8'h4F, "R3 block limit", rx_cnt, 16);

        // R5 open frame pool-ready, then R7 underrun and R10 lock.
        blk_sel = 1'b1;
        rd_stat(v);
        clear_rx();
        abort_cnt = 0;
        line_ready = 1'b0;
        for (int i = 0; i < 32; i++) put(8'(i));
        cmd(1'b0);
        tick(3);
        check(stat_q[0], "R5 pool-ready with space", stat_q, 1);
        rd_stat(v);
        for (int i = 32; i < 64; i++) put(8'(i));
        cmd(1'b0);
        tick(3);
        check(!stat_q[0], "R5 no pool-ready when full", stat_q, 0);
        line_ready = 1'b1;
        tick(34);
        check(stat_q[0], "R5 pool-ready after first block", stat_q, 1);
        tick(40);
        check(rx_cnt == 64, "R7 drained count", rx_cnt, 64);
        check(abort_cnt == 1, "R7 single abort", abort_cnt, 1);
        check(stat_q == 8'h03, "R7 underrun status", stat_q, 8'h03);
        check(wr_lock, "R10 locked after underrun", wr_lock, 1);
        put(8'hEE);
        rd_stat(v);
        tick(1);
        check(!wr_lock, "R10 lock released by read", wr_lock, 0);
        short_frame(8'hE0, "R10 locked write ignored");

        // R8: collision after first block, repeat bit unmasked.
        set_mask(8'hF8);
        blk_sel = 1'b0;
        rd_stat(v);
        clear_rx();
        abort_cnt = 0;
        line_ready = 1'b0;
        for (int i = 0; i < 16; i++) put(8'h50 + 8'(i));
        cmd(1'b0);
        for (int i = 16; i < 32; i++) put(8'h50 + 8'(i));
        cmd(1'b0);
        line_ready = 1'b1;
        tick(18);
        line_ready = 1'b0; coll_in = 1'b1;
        tick(1);
        coll_in = 1'b0;
        tick(2);
        check(wr_lock && irq && stat_q[2], "R8 repeat raised",
              {wr_lock, irq, stat_q[2]}, 3'b111);
        check(abort_cnt == 0 && !line_valid, "R8 frame dropped no abort",
              abort_cnt, 0);
        put(8'h77);
        rd_stat(v);
        check(v == 8'h05, "R8 status read", v, 8'h05);
        tick(1);
        check(!wr_lock, "R10 released after repeat read", wr_lock, 0);
        short_frame(8'h90, "R10 write during repeat lock ignored");

        // R9: collision inside first block restarts the frame.
        rd_stat(v);
        clear_rx();
        line_ready = 1'b0;
        for (int i = 0; i < 10; i++) put(8'h30 + 8'(i));
        cmd(1'b1);
        line_ready = 1'b1;
        tick(3);
        line_ready = 1'b0; coll_in = 1'b1;
        tick(1);
        coll_in = 1'b0; line_ready = 1'b1;
        tick(15);
        bad = 0;
        for (int i = 0; i < 10; i++) if (rx[3+i] != 8'h30 + 8'(i)) bad++;
        check(rx_cnt == 13 && bad == 0 && rx[2] == 8'h32, "R9 auto restart",
              rx_cnt, 13);
        check(stat_q == 8'h01, "R9 no repeat status", stat_q, 8'h01);

        // R11: masked repeat keeps the lock.
        set_mask(8'hFC);
        rd_stat(v);
        line_ready = 1'b0;
        for (int i = 0; i < 16; i++) put(8'(i));
        cmd(1'b0);
        for (int i = 0; i < 16; i++) put(8'(i));
        cmd(1'b0);
        line_ready = 1'b1;
        tick(18);
        line_ready = 1'b0; coll_in = 1'b1;
        tick(1);
        coll_in = 1'b0;
        tick(1);
        rd_stat(v);
        check(v[2] == 1'b0, "R11 masked bit hidden", v, 0);
        tick(1);
        check(wr_lock, "R11 lock kept after read", wr_lock, 1);
        set_mask(8'hF8);
        check(irq, "R2 unmask shows pending bit", irq, 1);
        rd_stat(v);
        check(v == 8'h04, "R11 unmasked read", v, 8'h04);
        tick(1);
        check(!wr_lock, "R11 lock released", wr_lock, 0);

        // R12: transmitter reset flushes and raises pool-ready.
        line_ready = 1'b0;
        for (int i = 0; i < 5; i++) put(8'hB0 + 8'(i));
        cmd_txreset = 1'b1;
        tick(1);
        cmd_txreset = 1'b0;
        tick(1);
        check(stat_q[0] && !line_valid, "R12 pool-ready after reset cmd",
              stat_q, 1);
        short_frame(8'hD0, "R12 FIFO flushed");

        finished = 1;
        summary();
        $finish;
    end
endmodule